// File: doc/BRIEF.md
# Programmable Interval Timer

A memory-mapped timer that raises a periodic, single-cycle interrupt. A 32-bit down-counter runs at the system clock rate while a run bit is set. When it reaches zero it reloads from a programmable delay register and keeps counting. Software programs a delay of N and then sets the run and interrupt-enable bits. From then on the interrupt line pulses once every N+1 cycles. Each pulse falls in the cycle in which the counter holds zero.

Software reaches the timer through a simple word-wide register port. The port carries an address, a write strobe with write data, and a read strobe with combinational read data. Pausing the counter keeps its value, so counting resumes where it stopped. Writing a new delay re-synchronises the counter at once. A delay of zero is handled deterministically: the counter stays at zero and no interrupt is raised.

Top module: `interval_timer`

## Requirements
- R1: Synchronous reset clears the control register, the delay register and the counter to zero. While the run bit stays clear after reset, the counter does not move and the interrupt stays low.
- R2: Register map (byte address, 4-bit port): 0x0 control (bit 0 run, bit 1 interrupt enable, bits 31:2 stored and read back as written), 0x4 delay, 0x8 read-only counter value. Writes to 0x8 are ignored. Reads of 0xC or of any address with bits 1:0 non-zero return zero, and writes to them have no effect. Read data is zero while the read strobe is low.
- R3: While the run bit is set and the counter is non-zero, the counter drops by one each cycle. While the run bit is clear, the counter holds its value.
- R4: A running counter at zero loads the delay value on the next cycle, so with delay N the counter repeats N, N-1, …, 0 and the interrupt period is N+1 cycles.
- R5: The interrupt is high for exactly one cycle, in the cycle in which the counter reads zero after counting down. A delay of 1 yields a 50% duty-cycle square wave.
- R6: The interrupt is raised only when both the run bit and the interrupt-enable bit are set. A stopped counter sitting at zero produces no interrupt.
- R7: Clearing and then setting the run bit resumes from the held value. If the counter was stopped right as it reached zero, the interrupt fires in the first running cycle, as if there had been no pause.
- R8: A write to the delay register while running sets the counter to the written value on the next cycle. A write while stopped clears the counter to zero.
- R9: When the run bit is set while the counter holds zero and did not count down to it (after reset or after a stopped delay write), the first running cycle loads the delay value and raises no interrupt.
- R10: With a delay of zero the running counter stays at zero and the interrupt stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt, active high, one cycle per period |

## Verification
The periodic function is tried with delays of 1, 2 and 9. These separate an off-by-one in the reload from a correct N+1 period, and the 50% square wave shows whether two pulses ever merge. Pause and resume are tried twice: once mid-count, where a reload on resume would show up in the read-back value, and once stopped exactly on zero, which tells apart a missing resumed pulse from a spurious pulse while stopped. A long random phase mixes small delays, control writes, ignored writes and misaligned reads against a cycle model. This exposes mistakes in the order between delay writes, reloads and the run bit.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_DLY  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CNT  = IDX_W'(2);

  logic [DATA_W-1:0] ctrl_q, dly_q, cnt_q;
  logic              live_q;

  wire              aligned = bus_addr[1:0] == 2'b00;
  wire [IDX_W-1:0]  idx     = bus_addr[ADDR_W-1:2];
  wire              ctrl_we = bus_wr && aligned && idx == IDX_CTRL;
  wire              dly_we  = bus_wr && aligned && idx == IDX_DLY;
  wire              run     = ctrl_q[0];
  wire              ien     = ctrl_q[1];
  wire              at_zero = cnt_q == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dly_q  <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= bus_wdata;
      if (dly_we) begin
        dly_q  <= bus_wdata;
        cnt_q  <= run ? bus_wdata : '0;
        live_q <= 1'b0;
      end else if (run) begin
        cnt_q  <= at_zero ? dly_q : cnt_q - 1'b1;
        live_q <= cnt_q == DATA_W'(1);
      end
    end
  end

  assign irq = run && ien && at_zero && live_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && aligned) begin
      case (idx)
        IDX_CTRL: bus_rdata = ctrl_q;
        IDX_DLY:  bus_rdata = dly_q;
        IDX_CNT:  bus_rdata = cnt_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic              run,
  input logic              ien,
  input logic [DATA_W-1:0] dly_q,
  input logic [DATA_W-1:0] cnt_q
);
  wire dly_hit = bus_wr && bus_addr == ADDR_W'(4);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && dly_q == '0 && !run && !ien));

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !dly_hit) |=> cnt_q == $past(cnt_q));

  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q != '0 && !dly_hit) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r4_reload_at_zero: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q == '0 && !dly_hit) |=> cnt_q == $past(dly_q));

  a_r5_irq_on_zero: assert property (@(posedge clk) disable iff (rst)
    irq |-> cnt_q == '0);

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> (run && ien));

  a_r8_write_running: assert property (@(posedge clk) disable iff (rst)
    (dly_hit && run) |=> cnt_q == $past(bus_wdata));

  a_r8_write_stopped: assert property (@(posedge clk) disable iff (rst)
    (dly_hit && !run) |=> cnt_q == '0);

  a_r10_zero_delay_quiet: assert property (@(posedge clk) disable iff (rst)
    dly_q == '0 |-> !irq);
endmodule

bind interval_timer interval_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .irq(irq), .run(ctrl_q[0]), .ien(ctrl_q[1]), .dly_q(dly_q), .cnt_q(cnt_q)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq;

  interval_timer u_dut (.clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .irq(irq));

  int checks = 0, errors = 0, cyc = 0, last_irq = 0, last_gap = 0, irq_count = 0;
  logic [31:0] m_ctrl, m_dly, m_cnt, last_rd;
  logic        m_live, last_irq_v;
  bit          done = 0;

  function automatic logic exp_irq();
    return m_ctrl[0] && m_ctrl[1] && m_cnt == 0 && m_live;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    if (a[1:0] != 2'b00) return 0;
    case (a[3:2])
      2'd0: return m_ctrl;
      2'd1: return m_dly;
      2'd2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    #1;
    last_rd = rdata; last_irq_v = irq;
    if (!rst) begin
      check("R5 irq vs model", {31'd0, irq}, {31'd0, exp_irq()});
      if (r) check("R2 read vs model", rdata, exp_rd(a));
      if (irq) begin last_gap = cyc - last_irq; last_irq = cyc; irq_count++; end
    end
    @(posedge clk);
    cyc++;
    if (rst) begin
      m_ctrl = 0; m_dly = 0; m_cnt = 0; m_live = 0;
    end else begin
      if (w && a == 4'h4) begin
        m_cnt = m_ctrl[0] ? d : 0; m_live = 0; m_dly = d;
      end else if (m_ctrl[0]) begin
        m_live = (m_cnt == 1);
        m_cnt = (m_cnt == 0) ? m_dly : m_cnt - 1;
      end
      if (w && a == 4'h0) m_ctrl = d;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
  endtask
  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    tick(1, 0, a, d);
  endtask
  task automatic rreg(input logic [3:0] a);
    tick(0, 1, a, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    idle(3);
    rst = 1'b0;
    rreg(4'h0); check("R1 ctrl after reset", last_rd, 0);
    rreg(4'h4); check("R1 delay after reset", last_rd, 0);
    idle(4);
    rreg(4'h8); check("R1 counter still zero", last_rd, 0);
    check("R1 irq low", {31'd0, last_irq_v}, 0);

    wreg(4'h4, 2);
    wreg(4'h0, 3);
    rreg(4'h8); check("R9 load cycle counter", last_rd, 0);
    check("R9 no irq in load cycle", {31'd0, last_irq_v}, 0);
    rreg(4'h8); check("R9 counter loaded", last_rd, 2);
    rreg(4'h8); check("R3 decrement", last_rd, 1);
    idle(12);
    check("R4 period for delay 2", last_gap, 3);

    wreg(4'h0, 32'hABCD_0003);
    rreg(4'h0); check("R2 control high bits", last_rd, 32'hABCD_0003);
    wreg(4'h8, 32'd123);
    rreg(4'h4); check("R2 counter write ignored", last_rd, 2);
    rreg(4'h9); check("R2 misaligned read", last_rd, 0);
    rreg(4'hC); check("R2 unused offset", last_rd, 0);

    wreg(4'h4, 1);
    idle(8);
    check("R5 square wave gap", last_gap, 2);

    wreg(4'h4, 9);
    idle(25);
    check("R4 period for delay 9", last_gap, 10);

    while (m_cnt != 5) idle(1);
    wreg(4'h0, 2);
    held = m_cnt;
    check("R3 held value nonzero", {31'd0, held == 4}, 1);
    idle(5);
    rreg(4'h8); check("R3 counter held", last_rd, 4);
    wreg(4'h0, 3);
    rreg(4'h8); check("R7 resume value", last_rd, 4);
    rreg(4'h8); check("R7 resume continues", last_rd, 3);

    while (m_cnt != 1) idle(1);
    wreg(4'h0, 2);
    idle(4);
    rreg(4'h8); check("R6 stopped at zero", last_rd, 0);
    check("R6 no irq while stopped", {31'd0, last_irq_v}, 0);
    wreg(4'h0, 3);
    rreg(4'h8);
    check("R7 pending zero fires on resume", {31'd0, last_irq_v}, 1);

    wreg(4'h0, 1);
    irq_count = 0;
    idle(25);
    check("R6 no irq when disabled", irq_count, 0);

    wreg(4'h4, 20);
    rreg(4'h8); check("R8 running delay write", last_rd, 20);
    rreg(4'h8); check("R8 continues from new value", last_rd, 19);

    wreg(4'h0, 3);
    wreg(4'h4, 0);
    irq_count = 0;
    idle(6);
    rreg(4'h8); check("R10 counter stays zero", last_rd, 0);
    check("R10 no irq", irq_count, 0);

    wreg(4'h0, 0);
    wreg(4'h4, 7);
    rreg(4'h8); check("R8 stopped write clears counter", last_rd, 0);

    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0: wreg(4'h4, $urandom % 7);
        1: wreg(4'h0, {$urandom % 32'h4000_0000, 2'($urandom)});
        2: wreg(4'h8, $urandom);
        3: wreg(4'($urandom), $urandom % 7);
        4, 5: rreg(4'($urandom));
        default: idle(1);
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule